// File: doc/BRIEF.md
# Two-Group Channel Request Arbiter

This block decides which one of 32 pending transfer-channel requests is serviced next by a shared data-movement engine. The channels are split into a low group (channels 0 to 15) and a high group (channels 16 to 31). Each group carries a one-bit group priority, and each channel carries a four-bit priority used inside its group. A mode bit selects between fixed-priority selection and rotating (round-robin) selection.

The winner is presented on a valid/ready grant stream. A grant is offered with `gnt_valid_o` and the channel number on `gnt_ch_o`. The engine takes it by raising `gnt_ready_i`. While a grant is offered and not taken, the grant is frozen: valid stays high, the channel number does not change, and new requests are not considered. A new arbitration happens on every clock edge where the output slot is empty or is being emptied. When both groups are given the same group priority, the block raises a configuration error and issues no new grant until the setting is corrected.

Top module: `dga_arb_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `gnt_valid_o` is 0 and `cfg_err_o` is 0. The reset settings are: group 0 priority 0, group 1 priority 1, and fixed mode (`ctl_rr_i` written as 0).
- R2: After reset, each channel's priority equals its index within its group (channel n gets n mod 16). In fixed mode, the highest-numbered pending channel of the chosen group therefore wins until priorities are rewritten.
- R3: Channels 0..15 form group 0 and channels 16..31 form group 1. In fixed mode, if the group with the larger group priority has any pending request, the winner comes from that group. Otherwise the winner comes from the other group.
- R4: In fixed mode, the pending channel with the largest channel priority value in the chosen group wins (0 is the lowest priority). When channel priorities are equal, the higher channel number wins. Writing `pri_wr_i` with `pri_wr_ch_i` and `pri_wr_val_i` sets one channel's priority.
- R5: In round-robin mode, the winner inside a group is the first pending channel after that group's last granted channel, wrapping from 15 back to 0. The last-granted pointer of each group starts at 15 and is updated on every grant in either mode.
- R6: In round-robin mode, the group other than the last granted group is preferred when it has a pending request. Otherwise the same group is served again. After reset the last granted group is 0, so group 1 is preferred first.
- R7: `cfg_err_o` is 1 exactly while the two group priorities are equal. While it is 1, no new grant is loaded, and `gnt_valid_o` falls at the next edge where the slot is free.
- R8: While `gnt_valid_o` is 1 and `gnt_ready_i` is 0, `gnt_valid_o` and `gnt_ch_o` hold their values and request changes have no effect.
- R9: When the slot is free and no request bit is set, `gnt_valid_o` is 0 after the edge. A loaded grant always names a channel whose request bit was set at the loading edge, and only one channel is granted at a time.
- R10: Writes through `ctl_wr_i` or `pri_wr_i` take effect from the cycle after the write edge. The arbitration at the write edge itself uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Pending request per channel |
| pri_wr_i | input | 1 | Write strobe for one channel priority |
| pri_wr_ch_i | input | 5 | Channel whose priority is written |
| pri_wr_val_i | input | 4 | New channel priority |
| ctl_wr_i | input | 1 | Write strobe for group priorities and mode |
| ctl_g0_pri_i | input | 1 | Group 0 priority value |
| ctl_g1_pri_i | input | 1 | Group 1 priority value |
| ctl_rr_i | input | 1 | 1 selects round-robin, 0 selects fixed |
| gnt_valid_o | output | 1 | Grant offered |
| gnt_ready_i | input | 1 | Engine accepts the offered grant |
| gnt_ch_o | output | 5 | Granted channel number |
| cfg_err_o | output | 1 | Group priorities are equal |

## Verification
The assertions take for granted that every input is a known value from the first edge after reset. They also assume the channel count is a power of two, so the rotating index wraps by truncation. The stimulus changes every input only on falling clock edges, and it draws write values only from the field ranges. Back-pressure on `gnt_ready_i` is exercised in long stretches, and some stretches set the group priorities equal on purpose so that the error gating is crossed from both sides.

// File: rtl/dga_pkg.sv
package dga_pkg;
  typedef enum logic {ARB_FIXED = 1'b0, ARB_ROTATE = 1'b1} arb_mode_e;
endpackage

// File: rtl/dga_cfg.sv
module dga_cfg
  import dga_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int GSZ   = 16,
  parameter int PW    = 4,
  parameter int GPW   = 1,
  localparam int CW   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_wr_i,
  input  logic [CW-1:0]     pri_wr_ch_i,
  input  logic [PW-1:0]     pri_wr_val_i,
  input  logic              ctl_wr_i,
  input  logic [GPW-1:0]    ctl_g0_pri_i,
  input  logic [GPW-1:0]    ctl_g1_pri_i,
  input  logic              ctl_rr_i,
  output logic [NCH*PW-1:0] pri_flat_o,
  output logic [GPW-1:0]    g0_pri_o,
  output logic [GPW-1:0]    g1_pri_o,
  output arb_mode_e         mode_o,
  output logic              err_o
);
  logic [PW-1:0] pri_q [NCH];

  // R2: per-channel priority registers, reset to index within group
  for (genvar c = 0; c < NCH; c++) begin : g_pri
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pri_q[c] <= PW'(c % GSZ);
      else if (pri_wr_i && (pri_wr_ch_i == CW'(c)))
        pri_q[c] <= pri_wr_val_i;
    end
    assign pri_flat_o[c*PW +: PW] = pri_q[c];
  end

  // R1/R10: group priorities and mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g0_pri_o <= '0;
      g1_pri_o <= GPW'(1);
      mode_o   <= ARB_FIXED;
    end else if (ctl_wr_i) begin
      g0_pri_o <= ctl_g0_pri_i;
      g1_pri_o <= ctl_g1_pri_i;
      mode_o   <= arb_mode_e'(ctl_rr_i);
    end
  end

  // R7: colliding group priorities
  assign err_o = (g0_pri_o == g1_pri_o);
endmodule

// File: rtl/dga_pick.sv
module dga_pick #(
  parameter int GSZ = 16,
  parameter int PW  = 4,
  localparam int IW = $clog2(GSZ)
) (
  input  logic [GSZ-1:0]    req_i,
  input  logic [GSZ*PW-1:0] pri_i,
  input  logic [IW-1:0]     last_i,
  input  logic              rotate_i,
  output logic              any_o,
  output logic [IW-1:0]     idx_o
);
  logic [IW-1:0] fix_idx, rot_idx;
  logic [PW-1:0] best_pri;
  logic          fix_found, rot_found;

  // R4: largest priority, ties go to the higher index
  always_comb begin
    fix_idx   = '0;
    best_pri  = '0;
    fix_found = 1'b0;
    for (int i = 0; i < GSZ; i++) begin
      if (req_i[i] && (!fix_found || pri_i[i*PW +: PW] >= best_pri)) begin
        fix_idx   = IW'(i);
        best_pri  = pri_i[i*PW +: PW];
        fix_found = 1'b1;
      end
    end
  end

  // R5: first pending index after the last grant, wrapping
  always_comb begin
    rot_idx   = '0;
    rot_found = 1'b0;
    for (int k = 1; k <= GSZ; k++) begin
      if (!rot_found && req_i[IW'(int'(last_i) + k)]) begin
        rot_idx   = IW'(int'(last_i) + k);
        rot_found = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
  assign idx_o = rotate_i ? rot_idx : fix_idx;

  // R9: the chosen index is always a pending one
  always_comb begin
    if (any_o) a_r9_pick_pending: assert (req_i[idx_o]);
  end
endmodule

// File: rtl/dga_arb_top.sv
module dga_arb_top
  import dga_pkg::*;
#(
  parameter int NCH = 32,
  parameter int PW  = 4,
  parameter int GPW = 1,
  localparam int NGRP = 2,
  localparam int GSZ  = NCH / NGRP,
  localparam int IW   = $clog2(GSZ),
  localparam int CW   = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           pri_wr_i,
  input  logic [CW-1:0]  pri_wr_ch_i,
  input  logic [PW-1:0]  pri_wr_val_i,
  input  logic           ctl_wr_i,
  input  logic [GPW-1:0] ctl_g0_pri_i,
  input  logic [GPW-1:0] ctl_g1_pri_i,
  input  logic           ctl_rr_i,
  output logic           gnt_valid_o,
  input  logic           gnt_ready_i,
  output logic [CW-1:0]  gnt_ch_o,
  output logic           cfg_err_o
);
  logic [NCH*PW-1:0] pri_flat;
  logic [GPW-1:0]    g0_pri, g1_pri;
  arb_mode_e         mode;
  logic              rotate;

  dga_cfg #(.NCH(NCH), .GSZ(GSZ), .PW(PW), .GPW(GPW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .pri_wr_i(pri_wr_i), .pri_wr_ch_i(pri_wr_ch_i), .pri_wr_val_i(pri_wr_val_i),
    .ctl_wr_i(ctl_wr_i), .ctl_g0_pri_i(ctl_g0_pri_i), .ctl_g1_pri_i(ctl_g1_pri_i),
    .ctl_rr_i(ctl_rr_i),
    .pri_flat_o(pri_flat), .g0_pri_o(g0_pri), .g1_pri_o(g1_pri),
    .mode_o(mode), .err_o(cfg_err_o)
  );

  assign rotate = (mode == ARB_ROTATE);

  logic [IW-1:0] last_idx_q [NGRP];
  logic [IW-1:0] grp_idx    [NGRP];
  logic [NGRP-1:0] grp_any;
  logic          last_grp_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    dga_pick #(.GSZ(GSZ), .PW(PW)) u_pick (
      .req_i(req_i[g*GSZ +: GSZ]),
      .pri_i(pri_flat[g*GSZ*PW +: GSZ*PW]),
      .last_i(last_idx_q[g]),
      .rotate_i(rotate),
      .any_o(grp_any[g]),
      .idx_o(grp_idx[g])
    );
  end

  logic pref_grp, sel_grp, slot_free, load;
  logic [CW-1:0] win_ch;

  // R3/R6: group choice
  always_comb begin
    pref_grp = rotate ? ~last_grp_q : (g1_pri > g0_pri);
    sel_grp  = grp_any[pref_grp] ? pref_grp : ~pref_grp;
    win_ch   = {sel_grp, grp_idx[sel_grp]};
  end

  assign slot_free = !gnt_valid_o || gnt_ready_i;
  assign load      = slot_free && (|grp_any) && !cfg_err_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid_o <= 1'b0;
      gnt_ch_o    <= '0;
      last_grp_q  <= 1'b0;
      for (int g = 0; g < NGRP; g++) last_idx_q[g] <= '1;
    end else if (slot_free) begin
      gnt_valid_o <= load;
      if (load) begin
        gnt_ch_o              <= win_ch;
        last_grp_q            <= sel_grp;
        last_idx_q[sel_grp]   <= grp_idx[sel_grp];
      end
    end
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !gnt_ready_i) |=> (gnt_valid_o && $stable(gnt_ch_o)));

  a_r9_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && (req_i == '0)) |=> !gnt_valid_o);

  a_r9_grant_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && (req_i != '0) && !cfg_err_o) |=>
      (gnt_valid_o && (($past(req_i) >> gnt_ch_o) & NCH'(1)) != '0));

  a_r7_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && cfg_err_o) |=> !gnt_valid_o);

  a_r3_high_group_first: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && !rotate && !cfg_err_o && grp_any[g1_pri > g0_pri]) |=>
      (gnt_ch_o[CW-1] == $past(g1_pri > g0_pri)));
endmodule

// File: tb/sim_dga_arb_top.sv
`timescale 1ns/1ps
module sim_dga_arb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] req = '0;
  logic pri_wr = 1'b0;
  logic [4:0] pri_ch = '0;
  logic [3:0] pri_val = '0;
  logic ctl_wr = 1'b0;
  logic g0v = 1'b0, g1v = 1'b0, rrv = 1'b0;
  logic rdy = 1'b0;
  logic gv, err;
  logic [4:0] gch;

  always #10 clk = ~clk;

  dga_arb_top u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .pri_wr_i(pri_wr), .pri_wr_ch_i(pri_ch), .pri_wr_val_i(pri_val),
    .ctl_wr_i(ctl_wr), .ctl_g0_pri_i(g0v), .ctl_g1_pri_i(g1v), .ctl_rr_i(rrv),
    .gnt_valid_o(gv), .gnt_ready_i(rdy), .gnt_ch_o(gch), .cfg_err_o(err)
  );

  int checks = 0, fails = 0;
  string tag = "R1";

  // behavioural reference model
  int mpri [32];
  int mg0, mg1, mrr, mv, mch, mlastg;
  int mlast [2];

  function automatic bit grp_has(int g);
    for (int i = 0; i < 16; i++) if (req[g*16+i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int pick_in(int g);
    int best = -1;
    if (mrr != 0) begin
      for (int k = 1; k <= 16; k++)
        if (req[g*16 + ((mlast[g] + k) % 16)]) return (mlast[g] + k) % 16;
    end else begin
      for (int i = 0; i < 16; i++)
        if (req[g*16+i] && (best < 0 || mpri[g*16+i] >= mpri[g*16+best])) best = i;
    end
    return best;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 32; c++) mpri[c] = c % 16;
      mg0 = 0; mg1 = 1; mrr = 0; mv = 0; mch = 0; mlastg = 0;
      mlast[0] = 15; mlast[1] = 15;
    end else begin
      if (mv == 0 || rdy) begin
        if (mg0 == mg1 || req == 32'h0) mv = 0;
        else begin
          int pref, g, w;
          pref = (mrr != 0) ? 1 - mlastg : ((mg1 > mg0) ? 1 : 0);
          g = grp_has(pref) ? pref : 1 - pref;
          w = pick_in(g);
          mv = 1; mch = g*16 + w; mlast[g] = w; mlastg = g;
        end
      end
      if (pri_wr) mpri[pri_ch] = pri_val;
      if (ctl_wr) begin mg0 = g0v; mg1 = g1v; mrr = rrv; end
    end
  end

  task automatic compare();
    checks++;
    if (gv !== mv[0]) begin
      fails++;
      $display("FAIL %s valid actual=%0b expected=%0d", tag, gv, mv);
    end
    checks++;
    if (err !== (mg0 == mg1)) begin
      fails++;
      $display("FAIL R7 err actual=%0b expected=%0b", err, (mg0 == mg1));
    end
    if (mv != 0) begin
      checks++;
      if (gch !== mch[4:0]) begin
        fails++;
        $display("FAIL %s channel actual=%0d expected=%0d", tag, gch, mch);
      end
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    pri_wr = 1'b0; ctl_wr = 1'b0;
  endtask

  task automatic phase(string t, int n, int rdy_pct, int dens, int wr_pct);
    tag = t;
    for (int i = 0; i < n; i++) begin
      cyc();
      case (dens)
        0: req = 32'h0;
        1: req = $urandom & $urandom & $urandom;
        default: req = $urandom;
      endcase
      if (dens == 0 && ($urandom % 4 == 0)) req = $urandom;
      rdy = (($urandom % 100) < rdy_pct);
      if (($urandom % 100) < wr_pct) begin
        pri_wr = 1'b1; pri_ch = 5'($urandom); pri_val = 4'($urandom % 3);
      end
    end
  endtask

  task automatic set_ctl(bit a, bit b, bit r);
    ctl_wr = 1'b1; g0v = a; g1v = b; rrv = r;
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    cyc();
    // R2/R3: default priorities, group 1 above group 0
    phase("R2", 300, 70, 1, 0);
    phase("R3", 200, 80, 2, 0);
    // R10: swap group priorities, takes effect next cycle
    set_ctl(1'b1, 1'b0, 1'b0);
    phase("R10", 200, 70, 1, 0);
    // R4: rewrite priorities to small values -> many ties
    phase("R4", 600, 70, 1, 30);
    // R5/R6: rotating mode
    set_ctl(1'b0, 1'b1, 1'b1);
    phase("R5", 600, 80, 1, 5);
    phase("R6", 400, 90, 2, 0);
    // R7: equal group priorities
    set_ctl(1'b1, 1'b1, 1'b1);
    phase("R7", 200, 60, 2, 0);
    set_ctl(1'b0, 1'b0, 1'b0);
    phase("R7", 100, 60, 2, 0);
    set_ctl(1'b0, 1'b1, 1'b0);
    // R8: heavy back-pressure
    phase("R8", 500, 15, 2, 5);
    // R9: mostly idle requests
    phase("R9", 400, 70, 0, 0);
    set_ctl(1'b1, 1'b0, 1'b1);
    phase("R9", 300, 50, 0, 10);
    cyc();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule